// File: doc/BRIEF.md
# Burst Write Capture with Byte Masks

This block is the write side of a quad-data-rate static memory. A write request arrives with its address on a rising clock edge. Over the next four half-cycles the block gathers four 18-bit data words, one on each clock edge. The first word is taken on a rising edge and the words then alternate between falling and rising edges. Each word comes with two byte-select bits, and each bit covers one 9-bit half of that word.

Once the fourth word is held, the block issues one 72-bit write to the memory array. This write carries an 8-bit byte mask, so halves whose select bit was low keep their stored contents. While the completed burst waits for its commit edge, the block also shows its address, data and mask on a pending-write port. A read path can forward from that port.

A request on the rising edge right after an accepted one is dropped. Held continuously, the select therefore starts a burst on every other rising edge. A burst that has been accepted always completes, whatever the select and data inputs do afterwards.

Top module: `qdr_wr_capture`

## Requirements
- R1: A rising edge with `wr_sel` high starts a burst, unless the previous rising edge started one. The burst takes `wr_addr` from the same edge.
- R2: A request on the rising edge right after an accepted one is ignored. With `wr_sel` held high, bursts start on every other rising edge.
- R3: For a burst started on rising edge n, the data words are taken as follows. Word 0 is `din` at rising edge n+1 and word 1 is `din` at the next falling edge. Word 2 is `din` at rising edge n+2 and word 3 is `din` at the falling edge after that. Word k occupies bits [18k+17:18k] of the 72-bit burst.
- R4: `bsel` is sampled together with each word. Mask bit 2k+j holds `bsel[j]` for word k, where `bsel[0]` covers word bits [8:0] and `bsel[1]` covers bits [17:9]. A high bit means the byte is written.
- R5: An array byte whose mask bit is low keeps its previous contents.
- R6: A burst started on rising edge n drives `arr_we` high for exactly the cycle after rising edge n+3. During that cycle `arr_addr`, `arr_wdata` and `arr_bmask` carry the burst's address, data and mask.
- R7: `pend_valid` is high from the falling edge that takes word 3 until the next rising edge. While it is high, `pend_addr`, `pend_data` and `pend_mask` equal the values committed at that rising edge.
- R8: While no burst is in flight, `din`, `bsel` and `wr_addr` cause no write. A burst that has started completes even if `wr_sel` goes low.
- R9: A synchronous reset (`rst` high at a rising edge) abandons all bursts in flight. After that edge, `arr_we` and `pend_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| wr_sel | input | 1 | Write request, sampled on rising edges |
| wr_addr | input | ADDR_W | Burst address, sampled with the request |
| din | input | 18 | Data word input |
| bsel | input | 2 | Byte selects for the current word, active high |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 72 | Array write data, word 0 in the low bits |
| arr_bmask | output | 8 | Array byte mask, one bit per 9-bit byte |
| pend_valid | output | 1 | Completed burst awaiting commit |
| pend_addr | output | ADDR_W | Address of the pending burst |
| pend_data | output | 72 | Data of the pending burst |
| pend_mask | output | 8 | Byte mask of the pending burst |

## Verification
The bench holds `wr_sel` high for long stretches. A design that accepted back-to-back requests would then issue writes on consecutive cycles or mix words from two bursts. Each burst's data is compared word by word and mask bit by mask bit, which catches a swapped rising/falling capture or an off-by-one edge as a misplaced 18-bit field. Some bursts carry all-zero and partial masks, and a byte-granular array model at the end then shows any masked-off byte that was overwritten. A reset is applied while a burst is in flight, and random data between bursts must never produce a write.

// File: rtl/qdrw_pkg.sv
`timescale 1ns/1ps
package qdrw_pkg;
    localparam int WORD_W  = 18;
    localparam int LANE_W  = 9;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int BEATS   = 4;
    localparam int PAIRS   = BEATS / 2;
    localparam int STAGES  = PAIRS + 1;
    localparam int BURST_W = WORD_W * BEATS;
    localparam int MASK_W  = LANES * BEATS;

    typedef struct packed {
        logic [LANES-1:0]  sel;
        logic [WORD_W-1:0] data;
    } beat_t;

    typedef beat_t [BEATS-1:0] burst_t;

    function automatic logic [BURST_W-1:0] burst_data(input burst_t b);
        logic [BURST_W-1:0] r;
        for (int k = 0; k < BEATS; k++) r[k*WORD_W +: WORD_W] = b[k].data;
        return r;
    endfunction

    function automatic logic [MASK_W-1:0] burst_mask(input burst_t b);
        logic [MASK_W-1:0] r;
        for (int k = 0; k < BEATS; k++) r[k*LANES +: LANES] = b[k].sel;
        return r;
    endfunction
endpackage

// File: rtl/qdrw_cmd_track.sv
`timescale 1ns/1ps
module qdrw_cmd_track #(
    parameter int ADDR_W = 10,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [STAGES-1:0] stage_v,
    output logic [ADDR_W-1:0] tail_addr
);
    logic              accept;
    logic [ADDR_W-1:0] addr_q [STAGES];

    // a stage-0 token means the previous rising edge accepted: drop this one
    assign accept = wr_sel & ~stage_v[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_v <= '0;
        end else begin
            stage_v[0] <= accept;
            for (int i = 1; i < STAGES; i++) stage_v[i] <= stage_v[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (accept) addr_q[0] <= wr_addr;
        for (int i = 1; i < STAGES; i++)
            if (stage_v[i-1]) addr_q[i] <= addr_q[i-1];
    end

    assign tail_addr = addr_q[STAGES-1];
endmodule

// File: rtl/qdrw_beat_slot.sv
`timescale 1ns/1ps
module qdrw_beat_slot
    import qdrw_pkg::*;
(
    input  logic              clk,
    input  logic              cap_rise,
    input  logic              cap_fall,
    input  logic [WORD_W-1:0] din,
    input  logic [LANES-1:0]  bsel,
    output beat_t             rise_q,
    output beat_t             fall_q
);
    always_ff @(posedge clk) begin
        if (cap_rise) rise_q <= '{sel: bsel, data: din};
    end

    always_ff @(negedge clk) begin
        if (cap_fall) fall_q <= '{sel: bsel, data: din};
    end
endmodule

// File: rtl/qdrw_commit.sv
`timescale 1ns/1ps
module qdrw_commit
    import qdrw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BURST_W-1:0] data,
    input  logic [MASK_W-1:0]  mask,
    output logic               arr_we,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic [BURST_W-1:0] arr_wdata,
    output logic [MASK_W-1:0]  arr_bmask,
    output logic               pend_valid
);
    logic last_taken;

    // set on the falling edge that stores the final word
    always_ff @(negedge clk) begin
        if (rst) last_taken <= 1'b0;
        else     last_taken <= commit;
    end

    assign pend_valid = commit & last_taken;

    always_ff @(posedge clk) begin
        if (rst) arr_we <= 1'b0;
        else     arr_we <= commit;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            arr_addr  <= addr;
            arr_wdata <= data;
            arr_bmask <= mask;
        end
    end
endmodule

// File: rtl/qdr_wr_capture.sv
`timescale 1ns/1ps
module qdr_wr_capture
    import qdrw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_sel,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  din,
    input  logic [LANES-1:0]   bsel,
    output logic               arr_we,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic [BURST_W-1:0] arr_wdata,
    output logic [MASK_W-1:0]  arr_bmask,
    output logic               pend_valid,
    output logic [ADDR_W-1:0]  pend_addr,
    output logic [BURST_W-1:0] pend_data,
    output logic [MASK_W-1:0]  pend_mask
);
    logic [STAGES-1:0] stage_v;
    beat_t             rise_w [PAIRS];
    beat_t             fall_w [PAIRS];
    burst_t            burst;

    qdrw_cmd_track #(.ADDR_W(ADDR_W), .STAGES(STAGES)) u_track (
        .clk       (clk),
        .rst       (rst),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .stage_v   (stage_v),
        .tail_addr (pend_addr)
    );

    // slot k takes word 2k on a rising edge and word 2k+1 on the following fall
    for (genvar k = 0; k < PAIRS; k++) begin : g_slot
        qdrw_beat_slot u_slot (
            .clk      (clk),
            .cap_rise (stage_v[k]),
            .cap_fall (stage_v[k+1]),
            .din      (din),
            .bsel     (bsel),
            .rise_q   (rise_w[k]),
            .fall_q   (fall_w[k])
        );
    end

    always_comb begin
        for (int k = 0; k < PAIRS; k++) begin
            burst[2*k]   = rise_w[k];
            burst[2*k+1] = fall_w[k];
        end
    end

    assign pend_data = burst_data(burst);
    assign pend_mask = burst_mask(burst);

    qdrw_commit #(.ADDR_W(ADDR_W)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .commit     (stage_v[STAGES-1]),
        .addr       (pend_addr),
        .data       (pend_data),
        .mask       (pend_mask),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata),
        .arr_bmask  (arr_bmask),
        .pend_valid (pend_valid)
    );
endmodule

// File: rtl/qdrw_checker.sv
`timescale 1ns/1ps
module qdrw_checker
    import qdrw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_sel,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [WORD_W-1:0]  din,
    input logic               arr_we,
    input logic [ADDR_W-1:0]  arr_addr,
    input logic [BURST_W-1:0] arr_wdata,
    input logic [MASK_W-1:0]  arr_bmask,
    input logic               pend_valid,
    input logic [ADDR_W-1:0]  pend_addr,
    input logic [BURST_W-1:0] pend_data,
    input logic [MASK_W-1:0]  pend_mask
);
    logic [2:0] since_rst;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assert_accept_fresh_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(wr_sel, 4) && !$past(wr_sel, 5)) |-> arr_we);

    assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !arr_we);

    assert_rise_words_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && since_rst >= 3'd3) |->
            (pend_data[WORD_W-1:0] == $past(din, 2)) &&
            (pend_data[3*WORD_W-1:2*WORD_W] == $past(din, 1)));

    assert_write_origin_R6: assert property (@(posedge clk) disable iff (rst)
        (arr_we && since_rst >= 3'd4) |->
            $past(wr_sel, 4) && (arr_addr == $past(wr_addr, 4)));

    assert_pending_commits_R7: assert property (@(posedge clk) disable iff (rst)
        pend_valid |=> arr_we && (arr_addr == $past(pend_addr)) &&
                       (arr_wdata == $past(pend_data)) &&
                       (arr_bmask == $past(pend_mask)));

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_quiet_R9: assert (!arr_we && !pend_valid);
        end
    end
endmodule

bind qdr_wr_capture qdrw_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_sel     (wr_sel),
    .wr_addr    (wr_addr),
    .din        (din),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata),
    .arr_bmask  (arr_bmask),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_data  (pend_data),
    .pend_mask  (pend_mask)
);

// File: tb/tb_qdr_wr_capture.sv
`timescale 1ns/1ps
module tb_qdr_wr_capture;
    localparam int AW = 10;
    localparam int NC = 1200;
    localparam int NA = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_sel;
    logic [AW-1:0] wr_addr;
    logic [17:0] din;
    logic [1:0]  bsel;
    logic        arr_we;
    logic [AW-1:0] arr_addr;
    logic [71:0] arr_wdata;
    logic [7:0]  arr_bmask;
    logic        pend_valid;
    logic [AW-1:0] pend_addr;
    logic [71:0] pend_data;
    logic [7:0]  pend_mask;

    always #2.5 clk = ~clk;

    qdr_wr_capture #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_addr(wr_addr), .din(din), .bsel(bsel),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_bmask(arr_bmask),
        .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_data(pend_data), .pend_mask(pend_mask)
    );

    logic          s_sel [NC+1];
    logic          s_rst [NC+1];
    logic          acc   [NC+1];
    logic [AW-1:0] s_adr [NC+1];
    logic [17:0]   s_rd  [NC+1];
    logic [17:0]   s_fd  [NC+1];
    logic [1:0]    s_rb  [NC+1];
    logic [1:0]    s_fb  [NC+1];
    logic [71:0]   rmem  [NA];
    logic [71:0]   dmem  [NA];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] exp_data(input int a, input int b);
        return {s_fd[b], s_rd[b], s_fd[a], s_rd[a]};
    endfunction

    function automatic logic [7:0] exp_mask(input int a, input int b);
        return {s_fb[b], s_rb[b], s_fb[a], s_rb[a]};
    endfunction

    function automatic logic [71:0] merge(input logic [71:0] old, input logic [71:0] nw, input logic [7:0] m);
        logic [71:0] r = old;
        for (int j = 0; j < 8; j++) if (m[j]) r[9*j +: 9] = nw[9*j +: 9];
        return r;
    endfunction

    // choose the rising-edge inputs of cycle n
    task automatic pick(input int n);
        s_rst[n] = (n < 4) || (n == 150) || (n == 151);
        s_adr[n] = AW'($urandom % NA);
        s_rd[n]  = 18'($urandom);
        s_rb[n]  = 2'($urandom);
        if (n < 4)        s_sel[n] = 1'b0;
        else if (n < 40)  begin s_sel[n] = 1'b1; s_rb[n] = 2'b11; end   // R2: held select
        else if (n < 80)  s_sel[n] = (n % 5 == 0);
        else if (n < 120) begin s_sel[n] = (n % 4 == 0); if (n % 8 < 3) s_rb[n] = 2'b00; end
        else if (n == 148) s_sel[n] = 1'b1;                               // R9: killed by reset
        else if (n > 140 && n < 156) s_sel[n] = 1'b0;
        else              s_sel[n] = 1'($urandom % 2);
        rst = s_rst[n]; wr_sel = s_sel[n]; wr_addr = s_adr[n]; din = s_rd[n]; bsel = s_rb[n];
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int a = 0; a < NA; a++) begin rmem[a] = '0; dmem[a] = '0; end
        pick(0);
        for (int t = 0; t < NC; t++) begin
            @(posedge clk); #1.25;
            acc[t] = !s_rst[t] && s_sel[t] && !(t > 0 && acc[t-1]);
            begin
                bit ew;
                string rq;
                ew = (t >= 3) && acc[t-3] && !s_rst[t-2] && !s_rst[t-1] && !s_rst[t];
                if (t >= 3 && (s_rst[t] || s_rst[t-1] || s_rst[t-2])) rq = "R9";
                else if (ew) rq = (t >= 2 && !s_sel[t-2]) ? "R8" : "R1";
                else if (t >= 3 && s_sel[t-3]) rq = "R2";
                else rq = "R8";
                chk(arr_we === ew, rq, {71'd0, arr_we}, {71'd0, ew});
                if (ew) begin
                    chk(arr_addr === s_adr[t-3], "R6", {62'd0, arr_addr}, {62'd0, s_adr[t-3]});
                    chk(arr_wdata === exp_data(t-2, t-1), "R3", arr_wdata, exp_data(t-2, t-1));
                    chk(arr_bmask === exp_mask(t-2, t-1), "R4", {64'd0, arr_bmask}, {64'd0, exp_mask(t-2, t-1)});
                    rmem[s_adr[t-3] % NA] = merge(rmem[s_adr[t-3] % NA], exp_data(t-2, t-1), exp_mask(t-2, t-1));
                end
                if (arr_we === 1'b1) dmem[arr_addr % NA] = merge(dmem[arr_addr % NA], arr_wdata, arr_bmask);
            end
            s_fd[t] = 18'($urandom);
            s_fb[t] = (t >= 80 && t < 120 && t % 8 < 3) ? 2'b00 : 2'($urandom);
            if (t >= 4 && t < 40) s_fb[t] = 2'b11;
            din = s_fd[t]; bsel = s_fb[t];
            @(negedge clk); #1.25;
            begin
                bit ep;
                ep = (t >= 2) && acc[t-2] && !s_rst[t-1] && !s_rst[t];
                chk(pend_valid === ep, ep ? "R7" : "R9", {71'd0, pend_valid}, {71'd0, ep});
                if (ep) begin
                    chk(pend_addr === s_adr[t-2], "R7", {62'd0, pend_addr}, {62'd0, s_adr[t-2]});
                    chk(pend_data === exp_data(t-1, t), "R7", pend_data, exp_data(t-1, t));
                    chk(pend_mask === exp_mask(t-1, t), "R7", {64'd0, pend_mask}, {64'd0, exp_mask(t-1, t)});
                end
            end
            pick(t + 1);
        end
        for (int a = 0; a < NA; a++) chk(dmem[a] === rmem[a], "R5", dmem[a], rmem[a]);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule